// File: doc/BRIEF.md
# Dual-Channel Lamp Fault Status Registers

This block keeps one 8-bit status word for each lamp channel of a two-lamp inverter controller. Each word combines live condition bits with event flags. The live bits show the channel fault level and, in the first channel only, the two supply-monitor comparators. The event flags remember a fault entry, a strike timeout, a qualified overvoltage, a lamp-out and an overcurrent. A host reads a word through a small access port. Reading a word clears its event flags. A write access is accepted but changes nothing.

Several conditions wipe the words. Some apply to both channels: supply undervoltage lockout, the hardware power-down pin, a one-cycle software power-down strobe, and any change of either supply-monitor level. A per-channel disable level wipes only that channel's word. While a level-type wipe source stays asserted, the word reads as zero and incoming events are dropped. The detectors that create the event pulses and levels are outside this block.

Top module: `fault_status_regs`

## Requirements
- R1: After reset, `rd_data` is 00h and both status words read back as 00h.
- R2: Bit 0 of a channel's word follows that channel's `fault_lvl` input while no wipe source is active. Bit 0 is never sticky.
- R3: Sticky flags are set by the following and stay set until cleared. Bit 1 is set by a rising edge of `fault_lvl`. Bit 2 is set by `strike_evt`. Bit 3 is set by `ovp_evt`. Bit 4 is set by `lout_evt`. Bit 5 is set by `ocur_evt`.
- R4: A read of a channel's address clears bits 5..1 of that word, even if the condition is still present. Live bits and the other channel's word are unaffected.
- R5: An event arriving in the same cycle as a read of its word is kept set after that read.
- R6: An access with `acc_we`=1 changes no status bit and does not clear sticky flags.
- R7: In the channel-0 word, bit 6 shows `svm_lo` and bit 7 shows `svm_hi`, both live. In the channel-1 word, bits 7..6 read 0.
- R8: Any of the following wipes both words to 00h: `uvlo`, `pdn_pin`, a `sw_pdn` strobe, or a change of either supply-monitor level. While `uvlo` or `pdn_pin` stays high, the words read 00h and events are dropped.
- R9: `ch_dis[c]` wipes and holds only channel c's word at 00h.
- R10: The channel-0 word is at address E0h and the channel-1 word at E1h. A read of any other address returns 00h and clears nothing.
- R11: `rd_data` takes the word value one cycle after a read access. It holds that value until the next read, including across write accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fault_lvl | input | 2 | Per-channel live fault level |
| strike_evt | input | 2 | Per-channel strike-timeout pulse |
| ovp_evt | input | 2 | Per-channel qualified overvoltage pulse |
| lout_evt | input | 2 | Per-channel lamp-out pulse |
| ocur_evt | input | 2 | Per-channel overcurrent pulse |
| svm_lo | input | 1 | Low supply-monitor comparator level |
| svm_hi | input | 1 | High supply-monitor comparator level |
| uvlo | input | 1 | Undervoltage lockout level |
| pdn_pin | input | 1 | Hardware power-down level |
| sw_pdn | input | 1 | Software power-down strobe |
| ch_dis | input | 2 | Per-channel disable level |
| acc_en | input | 1 | Access strobe |
| acc_we | input | 1 | Access is a write (ignored) |
| acc_addr | input | 8 | Access address |
| rd_data | output | 8 | Registered read data |

## Verification
The assertions assume the following about the inputs. Every input is synchronous to `clk`. Event pulses and the software power-down strobe are single-cycle. Access strobes last one cycle. Supply-monitor levels start low after reset, so the first edge does not produce a spurious wipe. The stimulus changes inputs only on the falling edge and keeps each pulse to one cycle. It also returns the supply monitors to low before unrelated scenarios, so every wipe in the run is one that a scenario intends.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
  localparam int STK_W = 5;
  localparam int WORD_W = 8;

  function automatic logic [WORD_W-1:0] pack_status(input logic rt_fault,
                                                    input logic [STK_W-1:0] stk,
                                                    input logic [1:0] supply);
    return {supply, stk, rt_fault};
  endfunction

  function automatic logic [7:0] chan_addr(input logic [7:0] base, input int c);
    return base + 8'(c);
  endfunction
endpackage

// File: rtl/fsr_clear_ctrl.sv
module fsr_clear_ctrl #(
  parameter int NCH = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           uvlo,
  input  logic           pdn_pin,
  input  logic           sw_pdn,
  input  logic           svm_lo,
  input  logic           svm_hi,
  input  logic [NCH-1:0] ch_dis,
  output logic           glb_clr,
  output logic [NCH-1:0] ch_clr
);
  logic [1:0] svm_prev;
  logic       svm_cross;

  always_ff @(posedge clk) begin
    if (!rst_n) svm_prev <= 2'b00;
    else        svm_prev <= {svm_hi, svm_lo};
  end

  assign svm_cross = ({svm_hi, svm_lo} != svm_prev);
  assign glb_clr   = uvlo | pdn_pin | sw_pdn | svm_cross;

  for (genvar c = 0; c < NCH; c++) begin : g_clr
    assign ch_clr[c] = glb_clr | ch_dis[c];
  end
endmodule

// File: rtl/fsr_sticky_bank.sv
module fsr_sticky_bank
  import fsr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             rd_hit,
  input  logic             fault_lvl,
  input  logic             strike_evt,
  input  logic             ovp_evt,
  input  logic             lout_evt,
  input  logic             ocur_evt,
  output logic [STK_W-1:0] set_vec,
  output logic [STK_W-1:0] sticky
);
  logic fault_prev;

  assign set_vec = {ocur_evt, lout_evt, ovp_evt, strike_evt, fault_lvl & ~fault_prev};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fault_prev <= 1'b0;
      sticky     <= '0;
    end else begin
      fault_prev <= fault_lvl;
      if (clr)         sticky <= '0;
      else if (rd_hit) sticky <= set_vec;
      else             sticky <= sticky | set_vec;
    end
  end
endmodule

// File: rtl/fsr_read_port.sv
module fsr_read_port
  import fsr_pkg::*;
#(
  parameter int              NCH       = 2,
  parameter int              ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'hE0
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           acc_en,
  input  logic                           acc_we,
  input  logic [ADDR_W-1:0]              acc_addr,
  input  logic [NCH-1:0][WORD_W-1:0]     words,
  output logic [NCH-1:0]                 rd_hit,
  output logic [WORD_W-1:0]              rd_data
);
  logic              rd_stb;
  logic [WORD_W-1:0] sel_word;

  assign rd_stb = acc_en & ~acc_we;

  for (genvar c = 0; c < NCH; c++) begin : g_dec
    localparam logic [ADDR_W-1:0] MY_ADDR = BASE_ADDR + ADDR_W'(c);
    assign rd_hit[c] = rd_stb & (acc_addr == MY_ADDR);
  end

  always_comb begin
    sel_word = '0;
    for (int c = 0; c < NCH; c++)
      if (rd_hit[c]) sel_word = words[c];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      rd_data <= '0;
    else if (rd_stb) rd_data <= sel_word;
  end
endmodule

// File: rtl/fault_status_regs.sv
module fault_status_regs
  import fsr_pkg::*;
#(
  parameter int                NCH       = 2,
  parameter int                ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'hE0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    fault_lvl,
  input  logic [NCH-1:0]    strike_evt,
  input  logic [NCH-1:0]    ovp_evt,
  input  logic [NCH-1:0]    lout_evt,
  input  logic [NCH-1:0]    ocur_evt,
  input  logic              svm_lo,
  input  logic              svm_hi,
  input  logic              uvlo,
  input  logic              pdn_pin,
  input  logic              sw_pdn,
  input  logic [NCH-1:0]    ch_dis,
  input  logic              acc_en,
  input  logic              acc_we,
  input  logic [ADDR_W-1:0] acc_addr,
  output logic [WORD_W-1:0] rd_data
);
  logic                          glb_clr;
  logic [NCH-1:0]                ch_clr;
  logic [NCH-1:0]                rd_hit;
  logic [NCH-1:0][STK_W-1:0]     sticky_bits;
  logic [NCH-1:0][STK_W-1:0]     set_bits;
  logic [NCH-1:0][WORD_W-1:0]    status_words;

  fsr_clear_ctrl #(.NCH(NCH)) u_clr (
    .clk(clk), .rst_n(rst_n), .uvlo(uvlo), .pdn_pin(pdn_pin), .sw_pdn(sw_pdn),
    .svm_lo(svm_lo), .svm_hi(svm_hi), .ch_dis(ch_dis),
    .glb_clr(glb_clr), .ch_clr(ch_clr)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [1:0] supply;
    if (c == 0) begin : g_sup
      assign supply = {svm_hi, svm_lo};
    end else begin : g_rsv
      assign supply = 2'b00;
    end

    fsr_sticky_bank u_bank (
      .clk(clk), .rst_n(rst_n), .clr(ch_clr[c]), .rd_hit(rd_hit[c]),
      .fault_lvl(fault_lvl[c]), .strike_evt(strike_evt[c]), .ovp_evt(ovp_evt[c]),
      .lout_evt(lout_evt[c]), .ocur_evt(ocur_evt[c]),
      .set_vec(set_bits[c]), .sticky(sticky_bits[c])
    );

    assign status_words[c] = ch_clr[c] ? '0
                           : pack_status(fault_lvl[c], sticky_bits[c], supply);
  end

  fsr_read_port #(.NCH(NCH), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_rd (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_we(acc_we), .acc_addr(acc_addr),
    .words(status_words), .rd_hit(rd_hit), .rd_data(rd_data)
  );
endmodule

// File: rtl/fsr_checker.sv
module fsr_checker
  import fsr_pkg::*;
#(
  parameter int                NCH       = 2,
  parameter int                ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'hE0
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [NCH-1:0]            fault_lvl,
  input logic                      uvlo,
  input logic                      pdn_pin,
  input logic                      sw_pdn,
  input logic [NCH-1:0]            ch_dis,
  input logic                      acc_en,
  input logic                      acc_we,
  input logic [ADDR_W-1:0]         acc_addr,
  input logic [WORD_W-1:0]         rd_data,
  input logic [NCH-1:0]            ch_clr,
  input logic [NCH-1:0]            rd_hit,
  input logic [NCH-1:0][STK_W-1:0] set_bits,
  input logic [NCH-1:0][STK_W-1:0] sticky_bits
);
  logic known_addr;
  always_comb begin
    known_addr = 1'b0;
    for (int c = 0; c < NCH; c++)
      if (acc_addr == BASE_ADDR + ADDR_W'(c)) known_addr = 1'b1;
  end

  p_rd_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_en && !acc_we) |=> $stable(rd_data));

  p_bad_addr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !acc_we && !known_addr) |=> rd_data == '0);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    p_read_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_hit[c] && set_bits[c] == '0) |=> sticky_bits[c] == '0);

    p_keep_event_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!ch_clr[c]) |=> ((sticky_bits[c] & $past(set_bits[c])) == $past(set_bits[c])));

    p_write_noclr_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_en && acc_we && !ch_clr[c])
        |=> ((sticky_bits[c] & $past(sticky_bits[c])) == $past(sticky_bits[c])));

    p_global_wipe_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (uvlo || pdn_pin || sw_pdn) |=> sticky_bits[c] == '0);

    p_chan_disable_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ch_dis[c] |=> sticky_bits[c] == '0);

    p_live_fault_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_hit[c] && !ch_clr[c]) |=> rd_data[0] == $past(fault_lvl[c]));

    if (c > 0) begin : g_rsv
      p_reserved_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hit[c] |=> rd_data[7:6] == 2'b00);
    end
  end
endmodule

bind fault_status_regs fsr_checker #(.NCH(NCH), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_fsr_chk (
  .clk(clk), .rst_n(rst_n), .fault_lvl(fault_lvl), .uvlo(uvlo), .pdn_pin(pdn_pin),
  .sw_pdn(sw_pdn), .ch_dis(ch_dis), .acc_en(acc_en), .acc_we(acc_we), .acc_addr(acc_addr),
  .rd_data(rd_data), .ch_clr(ch_clr), .rd_hit(rd_hit), .set_bits(set_bits),
  .sticky_bits(sticky_bits)
);

// File: tb/test_fault_status_regs.sv
`timescale 1ns/1ps
module test_fault_status_regs;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] fault_lvl = '0, strike_evt = '0, ovp_evt = '0, lout_evt = '0, ocur_evt = '0;
  logic       svm_lo = 1'b0, svm_hi = 1'b0, uvlo = 1'b0, pdn_pin = 1'b0, sw_pdn = 1'b0;
  logic [1:0] ch_dis = '0;
  logic       acc_en = 1'b0, acc_we = 1'b0;
  logic [7:0] acc_addr = '0;
  logic [7:0] rd_data;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  always #2 clk = ~clk;

  fault_status_regs i_fault_status_regs (
    .clk(clk), .rst_n(rst_n), .fault_lvl(fault_lvl), .strike_evt(strike_evt),
    .ovp_evt(ovp_evt), .lout_evt(lout_evt), .ocur_evt(ocur_evt), .svm_lo(svm_lo),
    .svm_hi(svm_hi), .uvlo(uvlo), .pdn_pin(pdn_pin), .sw_pdn(sw_pdn), .ch_dis(ch_dis),
    .acc_en(acc_en), .acc_we(acc_we), .acc_addr(acc_addr), .rd_data(rd_data)
  );

  // behavioural reference model
  logic [4:0] m_stk [2];
  logic [1:0] m_fprev, m_sv;
  logic [7:0] m_rd;

  always @(posedge clk) begin
    logic g, clr;
    logic [4:0] setv;
    logic [7:0] view [2];
    if (!rst_n) begin
      m_stk[0] <= '0; m_stk[1] <= '0; m_fprev <= '0; m_sv <= '0; m_rd <= '0;
    end else begin
      g = uvlo | pdn_pin | sw_pdn | ({svm_hi, svm_lo} != m_sv);
      for (int c = 0; c < 2; c++) begin
        clr = g | ch_dis[c];
        setv = {ocur_evt[c], lout_evt[c], ovp_evt[c], strike_evt[c], fault_lvl[c] & ~m_fprev[c]};
        view[c] = clr ? 8'h00 : {(c == 0) ? {svm_hi, svm_lo} : 2'b00, m_stk[c], fault_lvl[c]};
        if (clr) m_stk[c] <= '0;
        else if (acc_en && !acc_we && acc_addr == 8'hE0 + 8'(c)) m_stk[c] <= setv;
        else m_stk[c] <= m_stk[c] | setv;
      end
      if (acc_en && !acc_we)
        m_rd <= (acc_addr == 8'hE0) ? view[0] : (acc_addr == 8'hE1) ? view[1] : 8'h00;
      m_fprev <= fault_lvl;
      m_sv <= {svm_hi, svm_lo};
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (rd_data !== m_rd) begin
        errors++;
        $display("FAIL R11 model compare: actual %02h expected %02h", rd_data, m_rd);
      end
    end
  end

  task automatic summary;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      summary();
    end
  end

  task automatic tick;
    @(negedge clk);
    strike_evt = '0; ovp_evt = '0; lout_evt = '0; ocur_evt = '0;
    sw_pdn = 0; acc_en = 0; acc_we = 0;
  endtask

  task automatic chk(input logic [7:0] exp, input string req);
    checks++;
    if (rd_data !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, rd_data, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string req);
    tick(); acc_en = 1; acc_addr = a;
    tick(); chk(exp, req);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk(8'h00, "R1 reset rd_data");
    rd(8'hE0, 8'h00, "R1 ch0 after reset");
    rd(8'hE1, 8'h00, "R1 ch1 after reset");
    // sticky set and read clear
    tick(); strike_evt[0] = 1; ovp_evt[1] = 1;
    rd(8'hE0, 8'h04, "R3 strike flag");
    rd(8'hE0, 8'h00, "R4 read clears");
    rd(8'hE1, 8'h08, "R3 ovp flag ch1");
    // live fault
    tick(); fault_lvl[0] = 1;
    rd(8'hE0, 8'h03, "R2 live+sticky fault");
    rd(8'hE0, 8'h01, "R2 live bit survives read");
    tick(); fault_lvl[0] = 0;
    rd(8'hE0, 8'h00, "R2 live bit follows");
    // same-cycle event and read
    tick(); ocur_evt[0] = 1;
    tick(); lout_evt[0] = 1; acc_en = 1; acc_addr = 8'hE0;
    tick(); chk(8'h20, "R5 read with new event");
    rd(8'hE0, 8'h10, "R5 event kept");
    // writes ignored
    tick(); ocur_evt[1] = 1;
    tick(); acc_en = 1; acc_we = 1; acc_addr = 8'hE1;
    tick(); chk(8'h10, "R11 write leaves rd_data");
    rd(8'hE1, 8'h20, "R6 write does not clear");
    tick(); tick(); chk(8'h20, "R11 hold while idle");
    // supply monitors
    tick(); strike_evt[0] = 1;
    tick(); svm_lo = 1;
    rd(8'hE0, 8'h40, "R7 svm_lo live, R8 crossing wipes");
    tick(); svm_hi = 1;
    rd(8'hE0, 8'hC0, "R7 svm_hi live");
    rd(8'hE1, 8'h00, "R7 ch1 reserved bits");
    tick(); svm_lo = 0; svm_hi = 0;
    rd(8'hE0, 8'h00, "R8 supply back low");
    // global wipes
    tick(); strike_evt = 2'b11;
    tick(); sw_pdn = 1;
    rd(8'hE0, 8'h00, "R8 sw power-down ch0");
    rd(8'hE1, 8'h00, "R8 sw power-down ch1");
    tick(); uvlo = 1;
    tick(); ovp_evt = 2'b11; fault_lvl[1] = 1;
    rd(8'hE1, 8'h00, "R8 uvlo holds zero");
    tick(); uvlo = 0;
    rd(8'hE1, 8'h01, "R8 events dropped under uvlo");
    tick(); fault_lvl[1] = 0; lout_evt = 2'b11;
    tick(); pdn_pin = 1;
    tick(); pdn_pin = 0;
    rd(8'hE0, 8'h00, "R8 power-down pin");
    // channel disable
    tick(); ocur_evt = 2'b11;
    tick(); ch_dis[1] = 1;
    rd(8'hE1, 8'h00, "R9 disabled channel wiped");
    rd(8'hE0, 8'h20, "R9 other channel kept");
    tick(); ch_dis[1] = 0;
    rd(8'hE1, 8'h00, "R9 stays clear after enable");
    // address decode
    tick(); ocur_evt[0] = 1;
    rd(8'hE2, 8'h00, "R10 unmapped address");
    rd(8'hE0, 8'h20, "R10 unmapped read clears nothing");
    tick(); tick();
    summary();
  end
endmodule